// File: doc/BRIEF.md
# Two-Cycle DMA Channel Engine

This block is one DMA channel that copies a run of units from a source pointer to a destination pointer. Each unit moves in two bus cycles: a read at the source pointer, then a write of the captured data at the destination pointer. Either pointer can address memory space or I/O space, so the channel handles memory-to-memory, memory-to-I/O and I/O-to-I/O runs. A unit is a byte or a word. Each pointer independently counts up, counts down or stays put after its own cycle.

Software loads the two pointers, a transfer count and a control word through a small write-only register port. Writing the control word with its arm bit set starts the run. The channel asks for the bus with a request/grant handshake and then runs its cycles. The start of each transfer can be left free-running, or it can be paced by a source request line or a destination request line. When the count runs out, the channel disarms itself and can pulse an interrupt.

Top module: `dma2c_engine`

## Requirements
- R1: Every transfer is a read cycle (`bus_we`=0) at the source pointer, followed directly by a write cycle (`bus_we`=1) at the destination pointer. The write data equals the `bus_rdata` value taken when the read was acknowledged.
- R2: `bus_io` shows control bit 2 (source in I/O space) during read cycles and control bit 3 (destination in I/O space) during write cycles.
- R3: Control bit 1 selects word units (1) or byte units (0). `bus_word` shows this bit during each cycle, and the pointer step size is 2 for words and 1 for bytes.
- R4: The source step is set by control bits [5:4] and the destination step by bits [7:6]. The encoding is 01 increment, 10 decrement, and 00 or 11 no change. The source pointer steps when its read is acknowledged; the destination pointer steps when its write is acknowledged.
- R5: Sync field bits [9:8] set to 00 or 11 means free-running. Transfers then follow back to back with no idle cycle, so an unstalled run of N units takes exactly 2N bus cycles.
- R6: Sync field 01 means source pacing. A transfer starts only while `src_drq` is high. `src_drq` is sampled when the channel is idle, and again as each non-final write is acknowledged, which lets the next read follow at once.
- R7: Sync field 10 means destination pacing. `dst_drq` is sampled only while idle, after a write has finished. Each transfer then ends by dropping `bus_req`, so a one-cycle pulse on `dst_drq` yields exactly one transfer.
- R8: The count decrements on each acknowledged write. The run ends and the channel disarms after the write that takes the count to zero. An arm request made while the count is zero is dropped.
- R9: When control bit 10 is set, `irq` is a one-cycle pulse in the cycle after the final write is acknowledged. It never fires otherwise.
- R10: `bus_req` is low at reset and rises one cycle before any bus cycle. No bus cycle starts until `bus_gnt` is seen high, and `bus_req` stays high through the whole transfer.
- R11: A bus cycle without `bus_ack` is held, with its address and direction stable, until it is acknowledged.
- R12: Register writes (address 0 source pointer, 1 destination pointer, 2 count, 3 control with arm in bit 0) take effect only while `bus_req` is low. Writes made during a transfer are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | RW | Register write data |
| src_drq | input | 1 | Source pacing request |
| dst_drq | input | 1 | Destination pacing request |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant |
| bus_cyc | output | 1 | Bus cycle active |
| bus_we | output | 1 | Cycle is a write |
| bus_io | output | 1 | Cycle targets I/O space |
| bus_word | output | 1 | Cycle moves a word |
| bus_addr | output | AW | Cycle address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ack | input | 1 | Cycle acknowledge |
| irq | output | 1 | End-of-run interrupt pulse |

## Verification
Two events can fall on the same clock edge. One is the acknowledgement of a run's final write; the other is a request line that says to continue, or a pacing pulse. The bench holds `src_drq` high through the last write of a source-paced run and then confirms that no further cycle or request appears. It also fires single `dst_drq` pulses and checks that each yields exactly one transfer, with the bus released in between. Random runs toggle both request lines and insert wait states and grant gaps at random. Every acknowledged cycle is compared with a pointer model kept in the bench.

// File: rtl/dma2c_pkg.sv
package dma2c_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dma_state_e;

  localparam int CB_ARM   = 0;
  localparam int CB_WORD  = 1;
  localparam int CB_SIO   = 2;
  localparam int CB_DIO   = 3;
  localparam int CB_SSTEP = 4;
  localparam int CB_DSTEP = 6;
  localparam int CB_SYNC  = 8;
  localparam int CB_IRQ   = 10;
  localparam int CTRL_W   = 11;

  localparam logic [1:0] STEP_UP   = 2'b01;
  localparam logic [1:0] STEP_DOWN = 2'b10;
  localparam logic [1:0] SYNC_SRC  = 2'b01;
  localparam logic [1:0] SYNC_DST  = 2'b10;
endpackage

// File: rtl/dma2c_ptr.sv
module dma2c_ptr #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          adv,
  input  logic [1:0]    mode,
  input  logic          word,
  output logic [AW-1:0] ptr
);
  import dma2c_pkg::*;

  logic [AW-1:0] stride;
  assign stride = word ? AW'(2) : AW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (load) begin
      ptr <= load_val;
    end else if (adv) begin
      if (mode == STEP_UP)        ptr <= ptr + stride;
      else if (mode == STEP_DOWN) ptr <= ptr - stride;
    end
  end
endmodule

// File: rtl/dma2c_seq.sv
module dma2c_seq (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_ok,
  input  logic                  more_ok,
  input  logic                  last,
  input  logic                  gnt,
  input  logic                  ack,
  output dma2c_pkg::dma_state_e state,
  output logic                  rd_fire,
  output logic                  wr_fire,
  output logic                  run_end
);
  import dma2c_pkg::*;

  dma_state_e nxt;

  assign rd_fire = (state == ST_RD) && ack;
  assign wr_fire = (state == ST_WR) && ack;
  assign run_end = wr_fire && last;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (start_ok) nxt = ST_REQ;
      ST_REQ:  if (gnt) nxt = ST_RD;
      ST_RD:   if (ack) nxt = ST_WR;
      ST_WR:   if (ack) nxt = (!last && more_ok) ? ST_RD : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/dma2c_engine.sv
module dma2c_engine #(
  parameter int AW = 20,
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_addr,
  input  logic [RW-1:0] cfg_wdata,
  input  logic          src_drq,
  input  logic          dst_drq,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          bus_cyc,
  output logic          bus_we,
  output logic          bus_io,
  output logic          bus_word,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_ack,
  output logic          irq
);
  import dma2c_pkg::*;

  localparam int NPTR = 2;

  dma_state_e        state;
  logic              rd_fire, wr_fire, run_end;
  logic [CTRL_W-1:0] ctrl_q;
  logic              armed_q;
  logic [CW-1:0]     cnt_q;
  logic [DW-1:0]     data_q;
  logic              irq_q;
  logic              reg_wr;
  logic [1:0]        sync_sel;
  logic              sync_dst;
  logic              go, more, last;
  logic [AW-1:0]     ptr [NPTR];
  logic [1:0]        step_sel [NPTR];
  logic              adv [NPTR];
  logic              unused_cfg;

  assign unused_cfg = ^cfg_wdata;

  assign reg_wr   = cfg_we && (state == ST_IDLE);
  assign sync_sel = ctrl_q[CB_SYNC +: 2];
  assign sync_dst = (sync_sel == SYNC_DST);
  assign last     = (cnt_q == CW'(1));

  always_comb begin
    case (sync_sel)
      SYNC_SRC: begin go = src_drq; more = src_drq; end
      SYNC_DST: begin go = dst_drq; more = 1'b0;    end
      default:  begin go = 1'b1;    more = 1'b1;    end
    endcase
  end

  dma2c_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_ok (armed_q && (cnt_q != '0) && go),
    .more_ok  (more),
    .last     (last),
    .gnt      (bus_gnt),
    .ack      (bus_ack),
    .state    (state),
    .rd_fire  (rd_fire),
    .wr_fire  (wr_fire),
    .run_end  (run_end)
  );

  assign step_sel[0] = ctrl_q[CB_SSTEP +: 2];
  assign step_sel[1] = ctrl_q[CB_DSTEP +: 2];
  assign adv[0]      = rd_fire;
  assign adv[1]      = wr_fire;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    dma2c_ptr #(.AW(AW)) u_ptr (
      .clk      (clk),
      .rst      (rst),
      .load     (reg_wr && (cfg_addr == 2'(g))),
      .load_val (cfg_wdata[AW-1:0]),
      .adv      (adv[g]),
      .mode     (step_sel[g]),
      .word     (ctrl_q[CB_WORD]),
      .ptr      (ptr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
      data_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= run_end && ctrl_q[CB_IRQ];
      if (rd_fire) data_q <= bus_rdata;
      if (wr_fire) cnt_q <= cnt_q - CW'(1);
      if (run_end) armed_q <= 1'b0;
      if (reg_wr && cfg_addr == 2'd2) cnt_q <= cfg_wdata[CW-1:0];
      if (reg_wr && cfg_addr == 2'd3) begin
        ctrl_q  <= cfg_wdata[CTRL_W-1:0];
        armed_q <= cfg_wdata[CB_ARM] && (cnt_q != '0);
      end
    end
  end

  assign bus_req   = (state != ST_IDLE);
  assign bus_cyc   = (state == ST_RD) || (state == ST_WR);
  assign bus_we    = (state == ST_WR);
  assign bus_addr  = bus_we ? ptr[1] : ptr[0];
  assign bus_io    = bus_we ? ctrl_q[CB_DIO] : ctrl_q[CB_SIO];
  assign bus_word  = ctrl_q[CB_WORD];
  assign bus_wdata = data_q;
  assign irq       = irq_q;
endmodule

// File: rtl/dma2c_engine_chk.sv
module dma2c_engine_chk #(
  parameter int AW = 20,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          bus_cyc,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          bus_ack,
  input logic          irq,
  input logic          sync_dst
);
  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_we && bus_ack) |=> (bus_cyc && bus_we)); // R1
  AST_WDATA_FROM_RD: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_we && bus_ack) |=> (bus_wdata == $past(bus_rdata))); // R1
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_cyc && !bus_ack) |=> (bus_cyc && $stable(bus_addr) && $stable(bus_we))); // R11
  AST_REQ_FIRST: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> !bus_cyc); // R10
  AST_NO_GNT_NO_CYC: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_cyc && !bus_gnt) |=> !bus_cyc); // R10
  AST_IRQ_AFTER_WR: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(bus_cyc && bus_we && bus_ack)); // R9
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq); // R9
  AST_DST_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sync_dst && bus_cyc && bus_we && bus_ack) |=> !bus_req); // R7
endmodule

bind dma2c_engine dma2c_engine_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req   (bus_req),
  .bus_gnt   (bus_gnt),
  .bus_cyc   (bus_cyc),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .bus_ack   (bus_ack),
  .irq       (irq),
  .sync_dst  (sync_dst)
);

// File: tb/dma2c_engine_tb_top.sv
`timescale 1ns/1ps
module dma2c_engine_tb_top;
  localparam int AW = 20;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int RW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [RW-1:0] cfg_wdata = '0;
  logic          src_drq = 1'b0, dst_drq = 1'b0;
  logic          bus_req, bus_cyc, bus_we, bus_io, bus_word, irq;
  logic          bus_gnt = 1'b0, bus_ack = 1'b0;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata = '0;

  always #10 clk = ~clk;

  dma2c_engine #(.AW(AW), .DW(DW), .CW(CW), .RW(RW)) dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .src_drq(src_drq), .dst_drq(dst_drq), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_io(bus_io), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq(irq));

  int checks = 0, fails = 0;
  // bench-side model of one run
  logic [AW-1:0] m_src, m_dst, hold_addr;
  logic [1:0]    m_sstep, m_dstep;
  logic          m_word, m_sio, m_dio;
  logic [DW-1:0] last_rd;
  int  exp_total, xfer_cnt, irq_cnt, cyc_seen;
  bit  phase, gnt_en, waits, drq_rand, was_held;

  function automatic logic [DW-1:0] memval(logic [AW-1:0] a, logic io);
    return {a[7:0] ^ 8'h5A, a[15:8] ^ (io ? 8'h3C : 8'hC3)};
  endfunction

  function automatic logic [AW-1:0] stepp(logic [AW-1:0] p, logic [1:0] m, logic w);
    logic [AW-1:0] s = w ? AW'(2) : AW'(1);
    if (m == 2'b01) return p + s;
    if (m == 2'b10) return p - s;
    return p;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one cycle: advance to the next falling edge, act as bus slave and check
  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irq) begin
        irq_cnt++;
        chk(xfer_cnt == exp_total, "R9 irq after final write", xfer_cnt, exp_total);
      end
      if (was_held) chk(bus_cyc && bus_addr == hold_addr, "R11 held cycle", bus_addr, hold_addr);
      if (drq_rand) begin src_drq = $urandom % 2; dst_drq = $urandom % 2; end
      bus_gnt = gnt_en && (!waits || ($urandom % 2 == 0));
      was_held = 1'b0;
      if (bus_cyc) begin
        cyc_seen++;
        bus_ack = !waits || ($urandom % 3 != 0);
        bus_rdata = memval(bus_addr, bus_io);
        if (!bus_ack) begin was_held = 1'b1; hold_addr = bus_addr; end
        else if (!bus_we) begin
          chk(phase == 1'b0, "R1 read while write due", phase, 0);
          chk(bus_addr == m_src, "R4 source address", bus_addr, m_src);
          chk(bus_io == m_sio, "R2 source space", bus_io, m_sio);
          chk(bus_word == m_word, "R3 unit size", bus_word, m_word);
          last_rd = bus_rdata;
          m_src = stepp(m_src, m_sstep, m_word);
          phase = 1'b1;
        end else begin
          chk(phase == 1'b1, "R1 write without read", phase, 1);
          chk(bus_addr == m_dst, "R4 destination address", bus_addr, m_dst);
          chk(bus_wdata == last_rd, "R1 write data", bus_wdata, last_rd);
          chk(bus_io == m_dio, "R2 destination space", bus_io, m_dio);
          m_dst = stepp(m_dst, m_dstep, m_word);
          phase = 1'b0;
          xfer_cnt++;
        end
      end else bus_ack = 1'b0;
    end
  endtask

  task automatic wr(logic [1:0] a, logic [RW-1:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1);
    cfg_we = 1'b0;
  endtask

  task automatic start(logic [AW-1:0] s, logic [AW-1:0] d, int cnt, bit w, bit sio, bit dio,
                       logic [1:0] ss, logic [1:0] ds, logic [1:0] sy, bit ie);
    m_src = s; m_dst = d; m_word = w; m_sio = sio; m_dio = dio; m_sstep = ss; m_dstep = ds;
    exp_total = cnt; xfer_cnt = 0; irq_cnt = 0; cyc_seen = 0; phase = 1'b0;
    wr(2'd0, RW'(s));
    wr(2'd1, RW'(d));
    wr(2'd2, RW'(cnt));
    wr(2'd3, RW'({ie, sy, ds, ss, dio, sio, w, 1'b1}));
  endtask

  task automatic wait_irq(int limit);
    for (int i = 0; i < limit && irq_cnt == 0; i++) tick(1);
  endtask

  initial begin
    process::self().srandom(32'h1D3A_5C07);
    gnt_en = 1'b1; waits = 1'b0; drq_rand = 1'b0; was_held = 1'b0;
    exp_total = 0; xfer_cnt = 0; irq_cnt = 0; phase = 1'b0;
    tick(4);
    rst = 1'b0;
    tick(2);
    chk(bus_req == 1'b0, "R10 reset request", bus_req, 0);
    chk(bus_cyc == 1'b0, "R10 reset cycle", bus_cyc, 0);
    chk(irq == 1'b0, "R9 reset irq", irq, 0);

    // free-running word copy, memory to memory
    start(20'h01000, 20'h02000, 4, 1, 0, 0, 2'b01, 2'b01, 2'b00, 1);
    wait_irq(200);
    chk(xfer_cnt == 4, "R8 transfer total", xfer_cnt, 4);
    chk(irq_cnt == 1, "R9 single irq", irq_cnt, 1);
    chk(cyc_seen == 8, "R5 back-to-back cycles", cyc_seen, 8);
    tick(3);

    // byte I/O to I/O, source decrement, destination fixed, source paced
    src_drq = 1'b0;
    start(20'h00480, 20'h00090, 5, 0, 1, 1, 2'b10, 2'b00, 2'b01, 1);
    tick(40);
    chk(xfer_cnt == 0, "R6 no start without src_drq", xfer_cnt, 0);
    chk(bus_req == 1'b0, "R6 bus idle without src_drq", bus_req, 0);
    src_drq = 1'b1;
    wait_irq(200);
    chk(xfer_cnt == 5, "R6 paced run total", xfer_cnt, 5);
    chk(cyc_seen == 10, "R6 lookahead keeps cycles adjacent", cyc_seen, 10);
    // final write coincided with src_drq high: must not continue
    tick(30);
    chk(xfer_cnt == 5, "R8 stop at zero despite request", xfer_cnt, 5);
    chk(bus_req == 1'b0, "R8 bus released at end", bus_req, 0);
    src_drq = 1'b0;

    // destination paced, memory to I/O, pulse stepping
    dst_drq = 1'b0;
    start(20'h0F000, 20'h00300, 3, 1, 0, 1, 2'b01, 2'b11, 2'b10, 1);
    tick(40);
    chk(xfer_cnt == 0, "R7 no start without dst_drq", xfer_cnt, 0);
    dst_drq = 1'b1; tick(1); dst_drq = 1'b0;
    tick(30);
    chk(xfer_cnt == 1, "R7 one pulse one transfer", xfer_cnt, 1);
    chk(bus_req == 1'b0, "R7 bus dropped between transfers", bus_req, 0);
    dst_drq = 1'b1; tick(1); dst_drq = 1'b0;
    tick(30);
    chk(xfer_cnt == 2, "R7 second pulse", xfer_cnt, 2);
    dst_drq = 1'b1;
    wait_irq(200);
    dst_drq = 1'b0;
    chk(xfer_cnt == 3, "R7 paced run total", xfer_cnt, 3);

    // arm with zero count is dropped
    start(20'h00100, 20'h00200, 0, 0, 0, 0, 2'b01, 2'b01, 2'b00, 1);
    tick(30);
    chk(bus_req == 1'b0, "R8 zero count never requests", bus_req, 0);
    chk(xfer_cnt == 0, "R8 zero count no transfer", xfer_cnt, 0);

    // grant withheld
    gnt_en = 1'b0;
    start(20'h03000, 20'h04000, 2, 1, 0, 0, 2'b01, 2'b10, 2'b00, 1);
    tick(20);
    chk(bus_req == 1'b1, "R10 request pending", bus_req, 1);
    chk(bus_cyc == 1'b0, "R10 no cycle before grant", bus_cyc, 0);
    gnt_en = 1'b1;
    wait_irq(200);
    chk(xfer_cnt == 2, "R10 run after grant", xfer_cnt, 2);

    // register writes during a run are ignored
    waits = 1'b1;
    start(20'h05000, 20'h06000, 6, 0, 0, 1, 2'b01, 2'b01, 2'b00, 1);
    while (xfer_cnt < 1) tick(1);
    wr(2'd0, RW'(20'h00000));
    wr(2'd1, RW'(20'h77777));
    wr(2'd2, RW'(1));
    wait_irq(500);
    chk(xfer_cnt == 6, "R12 busy writes ignored", xfer_cnt, 6);
    waits = 1'b0;

    // interrupt disabled
    start(20'h08000, 20'h09000, 3, 1, 0, 0, 2'b00, 2'b01, 2'b00, 0);
    tick(40);
    chk(xfer_cnt == 3, "R8 run without irq", xfer_cnt, 3);
    chk(irq_cnt == 0, "R9 irq disabled", irq_cnt, 0);

    // random runs
    for (int r = 0; r < 30; r++) begin
      int cnt = 1 + ($urandom % 8);
      logic [1:0] sy = 2'($urandom % 4);
      waits = $urandom % 2;
      drq_rand = 1'b1;
      start(AW'($urandom), AW'($urandom), cnt, $urandom % 2, $urandom % 2, $urandom % 2,
            2'($urandom), 2'($urandom), sy, 1);
      wait_irq(3000);
      drq_rand = 1'b0; src_drq = 1'b0; dst_drq = 1'b0;
      chk(xfer_cnt == cnt, "R8 random run total", xfer_cnt, cnt);
      chk(irq_cnt == 1, "R9 random run irq", irq_cnt, 1);
      tick(3);
    end

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails + 1);
    $finish;
  end
endmodule